// File: doc/BRIEF.md
# ADC Conversion Command Queue Sequencer

This block walks a 64-entry table of conversion command words on behalf of two queues that share it, and asks an external analog-to-digital converter for one conversion per word through a request/done handshake. Queue 1 always begins at entry 0. Queue 2 begins at a programmable start index, and that index also marks where queue 1 stops. Each command word names an input channel and may carry a pause mark.

A trigger pulse starts a queue or resumes a paused one. The sequencer then reads words in ascending order. It stops at an end-of-queue condition: a sentinel channel code, the queue 2 start index while queue 1 is running, or running past the last entry. Each queue reports a two-bit state and has a sticky pause flag and a sticky completion flag. Software clears a flag by writing 1 to it. The pause flags, gated by per-queue enables, drive a single interrupt line.

Top module: `adc_queue_seq`

## Requirements
- R1: A command word is 7 bits wide: bits [5:0] hold the channel and bit 6 holds the pause mark. Words are written through `tbl_we`/`tbl_addr`/`tbl_wdata`. After a queue 1 trigger, one `conv_req` is issued per entry, starting at entry 0 and going in ascending order. `conv_chan` carries that entry's channel and stays stable until `conv_done`.
- R2: Channel code 63 is the end-of-queue marker. Reaching it issues no conversion, sets the running queue's completion flag and returns that queue to idle (status 00). This includes the case where it is the first word read.
- R3: A word with its pause mark set is converted first. The queue then sets its pause flag and enters paused (status 10). A later trigger resumes the queue at the word after the pausing one.
- R4: If a pausing word is directly followed by an end-of-queue condition, both the pause flag and the completion flag are set, and the queue ends idle, not paused.
- R5: While queue 1 runs, reaching the index held in `q2_begin` ends queue 1. When `q2_begin` is 0, a queue 1 trigger completes with no conversion.
- R6: Queue 2 starts at entry `q2_begin`. If `q2_begin` is in the range 64 to 127, a queue 2 trigger completes at once with no conversion.
- R7: Running past entry 63 is an end-of-queue condition. A pause mark on entry 63 therefore yields the pause flag, the completion flag and idle.
- R8: When several end-of-queue conditions coincide, only the running queue gets its completion flag and returns to idle.
- R9: Queue 1 has priority. A queue 2 trigger that arrives while queue 1 is active is held, and queue 2 starts once queue 1 is idle or paused. A trigger to a queue that is already active is ignored. At most one queue is active at a time.
- R10: The pause and completion flags are sticky. Driving a bit of `clr_pause`/`clr_comp` high for a cycle clears only the corresponding flag, bit 0 for queue 1 and bit 1 for queue 2.
- R11: After reset, both queues are idle, all flags are 0 and `conv_req` is low.
- R12: `pause_irq` is high exactly when some queue has both its pause flag set and its bit of `pause_irq_en` set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tbl_we | input | 1 | Command table write enable |
| tbl_addr | input | 6 | Command table write index |
| tbl_wdata | input | 7 | Command word: [6] pause mark, [5:0] channel |
| q2_begin | input | 7 | Queue 2 start index (64 to 127 means empty) |
| trig | input | 2 | Trigger pulses, bit 0 queue 1, bit 1 queue 2 |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 6 | Channel for the requested conversion |
| conv_done | input | 1 | Converter finished the requested conversion |
| q1_status | output | 2 | Queue 1 state: 00 idle, 01 active, 10 paused |
| q2_status | output | 2 | Queue 2 state: 00 idle, 01 active, 10 paused |
| pause_flag | output | 2 | Sticky pause flags, one per queue |
| comp_flag | output | 2 | Sticky completion flags, one per queue |
| clr_pause | input | 2 | Write-1 clear of pause flags |
| clr_comp | input | 2 | Write-1 clear of completion flags |
| pause_irq_en | input | 2 | Per-queue pause interrupt enables |
| pause_irq | output | 1 | Pause interrupt |

## Verification
Two functions can fall on one command word or on adjacent words: a pause and an end-of-queue condition. This happens when a pausing word is followed by the sentinel code, and when the pause mark sits on the last table entry. The sentinel code and the queue 2 start boundary can also land on the same entry. The bench arranges each of these by writing the table and setting `q2_begin`. It then judges the outcome by the number and channels of the conversions requested, by which flags of which queue end up set, and by the queue ending idle rather than paused.

// File: rtl/adc_seq_pkg.sv
// Package: shared types and constants for the conversion queue sequencer.
// Assumes two queues sharing one command table.
package adc_seq_pkg;
    localparam int NUM_Q = 2;

    typedef enum logic [1:0] {
        QS_IDLE   = 2'b00,
        QS_ACTIVE = 2'b01,
        QS_PAUSED = 2'b10
    } qstat_e;

    typedef enum logic [1:0] {
        EN_IDLE  = 2'b00,
        EN_FETCH = 2'b01,
        EN_CONV  = 2'b10
    } eng_e;
endpackage

// File: rtl/ccw_table.sv
// Module: command word register file, one write port and one combinational read port.
// Assumes the write index is always in range; contents reset to zero.
module ccw_table #(
    parameter int DEPTH  = 64,
    parameter int WORD_W = 7,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    logic [WORD_W-1:0] mem [DEPTH];

    // Purpose: store written command words, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
    end

    // Purpose: present the addressed word to the sequencer.
    always_comb rd_data = mem[rd_addr];
endmodule

// File: rtl/queue_status.sv
// Module: per-queue state register with sticky pause and completion flags.
// Assumes start/park/finish are mutually exclusive and come from the sequencer engine.
module queue_status
    import adc_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   park,
    input  logic   finish,
    input  logic   set_pause,
    input  logic   clr_pause,
    input  logic   clr_comp,
    output qstat_e status,
    output logic   pause_flag,
    output logic   comp_flag
);
    // Purpose: track idle / active / paused.
    always_ff @(posedge clk) begin
        if (!rst_n)      status <= QS_IDLE;
        else if (start)  status <= QS_ACTIVE;
        else if (park)   status <= QS_PAUSED;
        else if (finish) status <= QS_IDLE;
    end

    // Purpose: sticky flags; a set event wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pause_flag <= 1'b0;
            comp_flag  <= 1'b0;
        end else begin
            if (set_pause)      pause_flag <= 1'b1;
            else if (clr_pause) pause_flag <= 1'b0;
            if (finish)         comp_flag  <= 1'b1;
            else if (clr_comp)  comp_flag  <= 1'b0;
        end
    end

    AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        status != 2'b11);                                              // R11
    AST_COMP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        comp_flag && !clr_comp |=> comp_flag);                         // R10
    AST_PAUSE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        pause_flag && !clr_pause |=> pause_flag);                      // R10
    AST_FINISH_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        finish |=> status == QS_IDLE && comp_flag);                    // R2
endmodule

// File: rtl/seq_engine.sv
// Module: shared sequencing engine. Arbitrates triggers, walks the table,
// detects end-of-queue conditions and runs the converter handshake.
// Assumes conv_done is only raised while conv_req is high.
module seq_engine
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CH_W  = 6,
    localparam int AW    = $clog2(DEPTH),
    localparam int PTR_W = AW + 1,
    localparam logic [CH_W-1:0] EOQ_CODE = {CH_W{1'b1}}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_Q-1:0]  trig,
    input  logic [PTR_W-1:0]  q2_begin,
    input  logic [NUM_Q-1:0]  q_active,
    input  logic [NUM_Q-1:0]  q_paused,
    output logic [AW-1:0]     rd_addr,
    input  logic [CH_W-1:0]   ccw_chan,
    input  logic              ccw_pause,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    output logic [NUM_Q-1:0]  start,
    output logic [NUM_Q-1:0]  park,
    output logic [NUM_Q-1:0]  finish,
    output logic [NUM_Q-1:0]  set_pause
);
    eng_e             state;
    logic             cur_q;
    logic [PTR_W-1:0] ptr;
    logic             pause_hold;
    logic             cur_pause;
    logic [NUM_Q-1:0] pend;
    logic [PTR_W-1:0] resume [NUM_Q];
    logic             sel_q;
    logic             at_eoq;

    // Purpose: choose the queue to start, queue 1 first.
    always_comb sel_q = !pend[0];

    // Purpose: combine all end-of-queue conditions for the current entry.
    always_comb begin
        at_eoq = (ptr >= PTR_W'(DEPTH)) || (ccw_chan == EOQ_CODE)
              || (!cur_q && ptr == q2_begin);
    end

    always_comb rd_addr  = ptr[AW-1:0];
    always_comb conv_req = (state == EN_CONV);

    // Purpose: one-cycle control strobes toward the per-queue status blocks.
    always_comb begin
        start     = '0;
        park      = '0;
        finish    = '0;
        set_pause = '0;
        case (state)
            EN_IDLE:  if (|pend) start[sel_q] = 1'b1;
            EN_FETCH: begin
                if (at_eoq)          finish[cur_q] = 1'b1;
                else if (pause_hold) park[cur_q]   = 1'b1;
            end
            EN_CONV:  if (conv_done && cur_pause) set_pause[cur_q] = 1'b1;
            default: ;
        endcase
    end

    // Purpose: latch triggers of non-active queues until they are started.
    always_ff @(posedge clk) begin
        if (!rst_n) pend <= '0;
        else        pend <= (pend | (trig & ~q_active)) & ~start;
    end

    // Purpose: engine state, pointer and resume points.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= EN_IDLE;
            cur_q      <= 1'b0;
            ptr        <= '0;
            pause_hold <= 1'b0;
            cur_pause  <= 1'b0;
            conv_chan  <= '0;
            for (int q = 0; q < NUM_Q; q++) resume[q] <= '0;
        end else begin
            case (state)
                EN_IDLE: if (|pend) begin
                    cur_q      <= sel_q;
                    pause_hold <= 1'b0;
                    state      <= EN_FETCH;
                    if (q_paused[sel_q]) ptr <= resume[sel_q];
                    else                 ptr <= sel_q ? q2_begin : '0;
                end
                EN_FETCH: begin
                    if (at_eoq) begin
                        state      <= EN_IDLE;
                        pause_hold <= 1'b0;
                    end else if (pause_hold) begin
                        resume[cur_q] <= ptr;
                        state         <= EN_IDLE;
                        pause_hold    <= 1'b0;
                    end else begin
                        conv_chan <= ccw_chan;
                        cur_pause <= ccw_pause;
                        state     <= EN_CONV;
                    end
                end
                EN_CONV: if (conv_done) begin
                    pause_hold <= cur_pause;
                    ptr        <= ptr + 1'b1;
                    state      <= EN_FETCH;
                end
                default: state <= EN_IDLE;
            endcase
        end
    end

    AST_REQ_NOT_EOQ: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req |-> conv_chan != EOQ_CODE);                           // R2
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        conv_req && !conv_done |=> conv_req && $stable(conv_chan));    // R1
    AST_SINGLE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(q_active[0] && q_active[1]));                                // R9
    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start));                                              // R9
    AST_END_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        |finish |=> !conv_req);                                        // R8
endmodule

// File: rtl/adc_queue_seq.sv
// Module: top of the two-queue conversion command sequencer.
// Assumes trig bits are single-cycle pulses and conv_done answers conv_req.
module adc_queue_seq
    import adc_seq_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CH_W  = 6,
    localparam int AW     = $clog2(DEPTH),
    localparam int PTR_W  = AW + 1,
    localparam int WORD_W = CH_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tbl_we,
    input  logic [AW-1:0]     tbl_addr,
    input  logic [WORD_W-1:0] tbl_wdata,
    input  logic [PTR_W-1:0]  q2_begin,
    input  logic [1:0]        trig,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    output logic [1:0]        q1_status,
    output logic [1:0]        q2_status,
    output logic [1:0]        pause_flag,
    output logic [1:0]        comp_flag,
    input  logic [1:0]        clr_pause,
    input  logic [1:0]        clr_comp,
    input  logic [1:0]        pause_irq_en,
    output logic              pause_irq
);
    logic [AW-1:0]     rd_addr;
    logic [WORD_W-1:0] rd_data;
    logic [NUM_Q-1:0]  start, park, finish, set_pause;
    logic [NUM_Q-1:0]  q_active, q_paused;
    qstat_e            qs [NUM_Q];

    ccw_table #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_table (
        .clk(clk), .rst_n(rst_n), .wr_en(tbl_we), .wr_addr(tbl_addr),
        .wr_data(tbl_wdata), .rd_addr(rd_addr), .rd_data(rd_data)
    );

    seq_engine #(.DEPTH(DEPTH), .CH_W(CH_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .trig(trig), .q2_begin(q2_begin),
        .q_active(q_active), .q_paused(q_paused), .rd_addr(rd_addr),
        .ccw_chan(rd_data[CH_W-1:0]), .ccw_pause(rd_data[CH_W]),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .start(start), .park(park), .finish(finish), .set_pause(set_pause)
    );

    for (genvar q = 0; q < NUM_Q; q++) begin : g_queue
        queue_status u_status (
            .clk(clk), .rst_n(rst_n), .start(start[q]), .park(park[q]),
            .finish(finish[q]), .set_pause(set_pause[q]),
            .clr_pause(clr_pause[q]), .clr_comp(clr_comp[q]),
            .status(qs[q]), .pause_flag(pause_flag[q]), .comp_flag(comp_flag[q])
        );
        always_comb q_active[q] = (qs[q] == QS_ACTIVE);
        always_comb q_paused[q] = (qs[q] == QS_PAUSED);
    end

    always_comb q1_status = qs[0];
    always_comb q2_status = qs[1];

    // Purpose: pause interrupt from enabled pause flags.
    always_comb pause_irq = |(pause_flag & pause_irq_en);

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        pause_irq |-> |pause_flag);                                    // R12
endmodule

// File: tb/test_adc_queue_seq.sv
module test_adc_queue_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tbl_we = 1'b0;
    logic [5:0] tbl_addr = '0;
    logic [6:0] tbl_wdata = '0;
    logic [6:0] q2_begin = 7'd100;
    logic [1:0] trig = '0;
    logic       conv_req;
    logic [5:0] conv_chan;
    logic       conv_done = 1'b0;
    logic [1:0] q1_status, q2_status, pause_flag, comp_flag;
    logic [1:0] clr_pause = '0, clr_comp = '0, pause_irq_en = '0;
    logic       pause_irq;

    int checks = 0;
    int errors = 0;
    int conv_cnt = 0;
    int conv_log [64];

    adc_queue_seq i_adc_queue_seq (
        .clk(clk), .rst_n(rst_n), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
        .tbl_wdata(tbl_wdata), .q2_begin(q2_begin), .trig(trig),
        .conv_req(conv_req), .conv_chan(conv_chan), .conv_done(conv_done),
        .q1_status(q1_status), .q2_status(q2_status), .pause_flag(pause_flag),
        .comp_flag(comp_flag), .clr_pause(clr_pause), .clr_comp(clr_comp),
        .pause_irq_en(pause_irq_en), .pause_irq(pause_irq)
    );

    always #2.5 clk = ~clk;

    // Converter model: answers each request one cycle later and logs the channel.
    initial forever begin
        @(negedge clk);
        if (conv_req && !conv_done) begin
            if (conv_cnt < 64) conv_log[conv_cnt] = int'(conv_chan);
            conv_cnt++;
            conv_done = 1'b1;
        end else begin
            conv_done = 1'b0;
        end
    end

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(int addr, int chan, bit pause);
        @(negedge clk);
        tbl_we = 1'b1; tbl_addr = 6'(addr); tbl_wdata = {pause, 6'(chan)};
        @(negedge clk);
        tbl_we = 1'b0;
    endtask

    task automatic pulse_trig(int q);
        @(negedge clk);
        trig[q] = 1'b1;
        @(negedge clk);
        trig = '0;
    endtask

    task automatic clear_all();
        @(negedge clk);
        clr_pause = 2'b11; clr_comp = 2'b11;
        @(negedge clk);
        clr_pause = '0; clr_comp = '0;
        conv_cnt = 0;
    endtask

    // Wait until no queue is active and no request is open for 4 cycles.
    task automatic settle();
        int quiet = 0;
        repeat (3) @(negedge clk);
        for (int n = 0; n < 3000 && quiet < 4; n++) begin
            @(negedge clk);
            if (q1_status != 2'b01 && q2_status != 2'b01 && !conv_req) quiet++;
            else quiet = 0;
        end
        if (quiet < 4) chk("settle timeout", 0, 1);
    endtask

    task automatic t_reset();
        chk("R11 q1_status", int'(q1_status), 0);
        chk("R11 q2_status", int'(q2_status), 0);
        chk("R11 flags", int'({pause_flag, comp_flag}), 0);
        chk("R11 conv_req", int'(conv_req), 0);
    endtask

    task automatic t_basic();
        clear_all();
        q2_begin = 7'd100;
        for (int i = 0; i < 5; i++) wr(i, 10 + i, 1'b0);
        wr(5, 63, 1'b0);
        pulse_trig(0);
        settle();
        chk("R1 conversion count", conv_cnt, 5);
        for (int i = 0; i < 5; i++) chk("R1 channel order", conv_log[i], 10 + i);
        chk("R2 q1 completion", int'(comp_flag), 1);
        chk("R2 q1 idle", int'(q1_status), 0);
        chk("R1 no pause", int'(pause_flag), 0);
        @(negedge clk); clr_comp = 2'b10; @(negedge clk); clr_comp = '0;
        @(negedge clk);
        chk("R10 clear other bit keeps flag", int'(comp_flag), 1);
        @(negedge clk); clr_comp = 2'b01; @(negedge clk); clr_comp = '0;
        @(negedge clk);
        chk("R10 write-1 clears flag", int'(comp_flag), 0);
    endtask

    task automatic t_first_eoq();
        clear_all();
        wr(0, 63, 1'b0);
        pulse_trig(0);
        settle();
        chk("R2 first word eoq no conversion", conv_cnt, 0);
        chk("R2 first word eoq completion", int'(comp_flag), 1);
        chk("R2 first word eoq idle", int'(q1_status), 0);
    endtask

    task automatic t_pause();
        clear_all();
        q2_begin = 7'd100;
        wr(0, 3, 1'b0); wr(1, 4, 1'b1); wr(2, 5, 1'b0); wr(3, 63, 1'b0);
        pulse_trig(0);
        settle();
        chk("R3 converts through pausing word", conv_cnt, 2);
        chk("R3 pause flag", int'(pause_flag), 1);
        chk("R3 paused status", int'(q1_status), 2);
        chk("R3 no completion yet", int'(comp_flag), 0);
        pause_irq_en = 2'b10;
        @(negedge clk);
        chk("R12 irq masked", int'(pause_irq), 0);
        pause_irq_en = 2'b01;
        @(negedge clk);
        chk("R12 irq enabled", int'(pause_irq), 1);
        pause_irq_en = 2'b00;
        pulse_trig(0);
        settle();
        chk("R3 resume count", conv_cnt, 3);
        chk("R3 resume at next word", conv_log[2], 5);
        chk("R3 completion after resume", int'(comp_flag), 1);
        chk("R3 idle after resume", int'(q1_status), 0);
    endtask

    task automatic t_pause_eoq();
        clear_all();
        wr(0, 7, 1'b1); wr(1, 63, 1'b0);
        pulse_trig(0);
        settle();
        chk("R4 one conversion", conv_cnt, 1);
        chk("R4 pause flag", int'(pause_flag), 1);
        chk("R4 completion flag", int'(comp_flag), 1);
        chk("R4 idle not paused", int'(q1_status), 0);
    endtask

    task automatic t_q2_begin();
        clear_all();
        wr(0, 1, 1'b0); wr(1, 2, 1'b0); wr(2, 3, 1'b0); wr(3, 20, 1'b0); wr(4, 63, 1'b0);
        q2_begin = 7'd2;
        pulse_trig(0);
        settle();
        chk("R5 q1 stops at q2 begin", conv_cnt, 2);
        chk("R5 q1 completion", int'(comp_flag), 1);
        conv_cnt = 0;
        pulse_trig(1);
        settle();
        chk("R6 q2 conversion count", conv_cnt, 2);
        chk("R6 q2 starts at begin", conv_log[0], 3);
        chk("R6 q2 second word", conv_log[1], 20);
        chk("R6 q2 completion", int'(comp_flag), 3);
        chk("R6 q2 idle", int'(q2_status), 0);
        clear_all();
        q2_begin = 7'd0;
        wr(0, 9, 1'b0);
        pulse_trig(0);
        settle();
        chk("R5 begin 0 no conversion", conv_cnt, 0);
        chk("R5 begin 0 completion", int'(comp_flag), 1);
    endtask

    task automatic t_q2_out();
        for (int k = 0; k < 2; k++) begin
            clear_all();
            q2_begin = (k == 0) ? 7'd64 : 7'd127;
            pulse_trig(1);
            settle();
            chk("R6 out-of-range no conversion", conv_cnt, 0);
            chk("R6 out-of-range completion", int'(comp_flag), 2);
            chk("R6 out-of-range idle", int'(q2_status), 0);
        end
    endtask

    task automatic t_last();
        clear_all();
        wr(60, 30, 1'b0); wr(61, 31, 1'b0); wr(62, 32, 1'b0); wr(63, 33, 1'b1);
        q2_begin = 7'd60;
        pulse_trig(1);
        settle();
        chk("R7 converts up to entry 63", conv_cnt, 4);
        chk("R7 last channel", conv_log[3], 33);
        chk("R7 pause flag", int'(pause_flag), 2);
        chk("R7 completion flag", int'(comp_flag), 2);
        chk("R7 idle", int'(q2_status), 0);
    endtask

    task automatic t_coincide();
        clear_all();
        q2_begin = 7'd0;
        wr(0, 63, 1'b0);
        pulse_trig(0);
        settle();
        chk("R8 no conversion", conv_cnt, 0);
        chk("R8 only q1 completion", int'(comp_flag), 1);
        chk("R8 both idle", int'({q1_status, q2_status}), 0);
    endtask

    task automatic t_priority();
        clear_all();
        q2_begin = 7'd10;
        for (int i = 0; i < 10; i++) wr(i, 1 + i, 1'b0);
        wr(10, 40, 1'b0); wr(11, 41, 1'b0); wr(12, 63, 1'b0);
        pulse_trig(0);
        repeat (4) @(negedge clk);
        chk("R9 q1 active", int'(q1_status), 1);
        trig = 2'b11;
        @(negedge clk);
        trig = '0;
        repeat (2) @(negedge clk);
        chk("R9 q2 held while q1 active", int'(q2_status), 0);
        settle();
        chk("R9 total conversions", conv_cnt, 12);
        chk("R9 q1 finished first", conv_log[9], 10);
        chk("R9 q2 after q1", conv_log[10], 40);
        chk("R9 both completed", int'(comp_flag), 3);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_first_eoq();
        t_pause();
        t_pause_eoq();
        t_q2_begin();
        t_q2_out();
        t_last();
        t_coincide();
        t_priority();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule